// File: doc/BRIEF.md
# Debug Lane Sampler with Change Compression

The block watches a set of 8-bit debug lanes, each accompanied by the native clock of the unit that produces it. On every cycle of its own fast sampling clock it looks at every lane. A lane whose native clock still toggles is compared with the last value kept for it, and a record is produced only when the value moved. A lane whose clock has gone quiet for a fixed number of sample cycles produces one marker record instead, and stays silent until its clock toggles again. Each record is stamped with a free-running cycle count of the sampling clock.

Records wait in small per-lane FIFOs. A round-robin arbiter drains them one at a time into a single registered output stage, using a 2-bit weight per lane to let busier lanes send short bursts. The output is a valid/ready stream of records. Each record carries the lane number, the timestamp, the data, two flag bits and a fixed source number of 1. It is meant to feed a trace collector that wraps records in its own protocol.

Top module: `lane_sampler`

## Requirements
- R1: While reset is held and right after it, outValid is 0 and every overflow bit is 0. Every record handed over carries outSrc equal to 1.
- R2: outTs is the value of a counter that reads 0 on the first sampling edge after reset and rises by one per cycle, taken on the cycle the lane was sampled.
- R3: A running lane yields a data record (flags 2'b00) only when its sampled value differs from the last value stored for it. The first sample after reset is always stored, with flags 2'b10.
- R4: A lane edge is a sampled lane clock that differs from the previous sample (taken as 0 at reset). After 8 consecutive sample cycles without an edge, exactly one clock-off record (flags 2'b01, data 0) is produced on the 8th such cycle, and no further record comes from that lane until an edge.
- R5: On the first edge after clock-off, that cycle's sample is stored whatever its value, with flags 2'b10, and normal compression resumes.
- R6: Records of one lane leave the output in the order they were sampled.
- R7: A lane whose FIFO holds FIFO_DEPTH records drops any new record and sets its overflow bit, which stays set until reset. With the output stalled, exactly FIFO_DEPTH+1 records of a lane are kept, the oldest ones.
- R8: The weight of lane i is laneWeight[2i+1:2i]. The lane being served keeps the grant for up to weight+1 consecutive records while it has data; then the grant goes to the next non-empty lane in ascending order, wrapping around. Lane 0 is served first after reset.
- R9: While outValid is 1 and outReady is 0, the record on the output holds still; one record moves per cycle with outValid and outReady both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneClk | input | NUM_LANES | Native clock of each lane, sampled as a level |
| laneData | input | NUM_LANES*LANE_W | Lane values, lane i in bits [8i+7:8i] |
| laneWeight | input | 2*NUM_LANES | Arbitration weight per lane |
| outReady | input | 1 | Downstream accepts a record |
| outValid | output | 1 | A record is on the output |
| outLane | output | 4 | Lane number of the record |
| outTs | output | TS_W | Timestamp of the record |
| outData | output | LANE_W | Sampled value, 0 for clock-off records |
| outFlags | output | 2 | Bit 0 clock-off, bit 1 restart |
| outSrc | output | 4 | Source number, always 1 |
| overflow | output | NUM_LANES | Sticky per-lane drop indication |

## Verification
The assertions take the lane weights as fixed from reset release onward, since the burst bound compares the running burst length with the weight of the served lane. They also take the timestamp as never wrapping inside a run, because a record's stamp is expected to lie strictly behind the live counter. The stimulus writes weights only while reset is held, and every run stays far shorter than the 32-bit timestamp range. Lane data and lane clocks are driven randomly, with stalls on the output and clock pauses both shorter and longer than the clock-off threshold.

// File: rtl/lane_sampler_pkg.sv
package lane_sampler_pkg;
  localparam int FLAG_W     = 2;
  localparam int FLAG_OFF   = 0;
  localparam int FLAG_RST   = 1;
  localparam int LANE_IDX_W = 4;
  localparam int SRC_W      = 4;

  typedef struct packed {
    logic                  load;
    logic [LANE_IDX_W-1:0] lane;
  } ls_strobe_t;
endpackage

// File: rtl/ls_lane_front.sv
module ls_lane_front
  import lane_sampler_pkg::*;
#(
  parameter int LANE_W     = 8,
  parameter int CLKOFF_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              laneClk,
  input  logic [LANE_W-1:0] laneData,
  output logic              recValid,
  output logic [LANE_W-1:0] recData,
  output logic [FLAG_W-1:0] recFlags
);
  localparam int CNT_W = $clog2(CLKOFF_CYC + 1);
  localparam logic [CNT_W-1:0] IDLE_MAX = CNT_W'(CLKOFF_CYC - 1);

  logic              prevClk;
  logic              offState;
  logic              havePrev;
  logic [CNT_W-1:0]  idleCnt;
  logic [LANE_W-1:0] lastData;
  logic              edgeSeen;
  logic              enterOff;
  logic              storeData;

  assign edgeSeen  = laneClk != prevClk;
  assign enterOff  = !edgeSeen && !offState && (idleCnt == IDLE_MAX);
  assign storeData = !enterOff && (edgeSeen || !offState) &&
                     (!havePrev || (laneData != lastData));

  assign recValid = storeData || enterOff;
  assign recData  = enterOff ? '0 : laneData;
  always_comb begin
    recFlags           = '0;
    recFlags[FLAG_OFF] = enterOff;
    recFlags[FLAG_RST] = storeData && !havePrev;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevClk  <= 1'b0;
      offState <= 1'b0;
      havePrev <= 1'b0;
      idleCnt  <= '0;
      lastData <= '0;
    end else begin
      prevClk <= laneClk;
      if (edgeSeen)
        idleCnt <= '0;
      else if (idleCnt != IDLE_MAX)
        idleCnt <= idleCnt + 1'b1;
      if (enterOff)
        offState <= 1'b1;
      else if (edgeSeen)
        offState <= 1'b0;
      if (enterOff)
        havePrev <= 1'b0;
      else if (storeData)
        havePrev <= 1'b1;
      if (storeData)
        lastData <= laneData;
    end
  end
endmodule

// File: rtl/ls_fifo.sv
module ls_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] fill;
  logic             doPush;
  logic             doPop;

  assign empty   = fill == '0;
  assign full    = fill == FULL_CNT;
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= pushData;
        wrPtr      <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (doPop)
        rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)
        fill <= fill + 1'b1;
      else if (doPop && !doPush)
        fill <= fill - 1'b1;
    end
  end
endmodule

// File: rtl/ls_datapath.sv
module ls_datapath
  import lane_sampler_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int LANE_W     = 8,
  parameter int TS_W       = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int CLKOFF_CYC = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_LANES-1:0]        laneClk,
  input  logic [NUM_LANES*LANE_W-1:0] laneData,
  input  ls_strobe_t                  strobe,
  input  logic                        outReady,
  output logic [NUM_LANES-1:0]        nonEmpty,
  output logic                        outValid,
  output logic [LANE_IDX_W-1:0]       outLane,
  output logic [TS_W-1:0]             outTs,
  output logic [LANE_W-1:0]           outData,
  output logic [FLAG_W-1:0]           outFlags,
  output logic [NUM_LANES-1:0]        overflow,
  output logic [TS_W-1:0]             tsNow
);
  localparam int REC_W = FLAG_W + TS_W + LANE_W;

  logic [REC_W-1:0] fifoOut [NUM_LANES];
  logic [REC_W-1:0] selRec;

  always_ff @(posedge clk) begin
    if (!rstN) tsNow <= '0;
    else       tsNow <= tsNow + 1'b1;
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic              recValid;
    logic [LANE_W-1:0] recData;
    logic [FLAG_W-1:0] recFlags;
    logic              fifoEmpty;
    logic              fifoFull;
    logic              popThis;

    assign popThis = strobe.load && (strobe.lane == LANE_IDX_W'(i));

    ls_lane_front #(.LANE_W(LANE_W), .CLKOFF_CYC(CLKOFF_CYC)) u_front (
      .clk      (clk),
      .rstN     (rstN),
      .laneClk  (laneClk[i]),
      .laneData (laneData[i*LANE_W +: LANE_W]),
      .recValid (recValid),
      .recData  (recData),
      .recFlags (recFlags)
    );

    ls_fifo #(.WIDTH(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .push     (recValid),
      .pushData ({recFlags, tsNow, recData}),
      .pop      (popThis),
      .popData  (fifoOut[i]),
      .empty    (fifoEmpty),
      .full     (fifoFull)
    );

    assign nonEmpty[i] = !fifoEmpty;

    always_ff @(posedge clk) begin
      if (!rstN)                     overflow[i] <= 1'b0;
      else if (recValid && fifoFull) overflow[i] <= 1'b1;
    end
  end

  always_comb begin
    selRec = '0;
    for (int i = 0; i < NUM_LANES; i++)
      if (strobe.lane == LANE_IDX_W'(i)) selRec = fifoOut[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLane  <= '0;
      outTs    <= '0;
      outData  <= '0;
      outFlags <= '0;
    end else if (strobe.load) begin
      outValid                     <= 1'b1;
      outLane                      <= strobe.lane;
      {outFlags, outTs, outData}   <= selRec;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/ls_arbiter.sv
module ls_arbiter
  import lane_sampler_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_LANES-1:0]   nonEmpty,
  input  logic [2*NUM_LANES-1:0] laneWeight,
  input  logic                   outValid,
  input  logic                   outReady,
  output ls_strobe_t             strobe,
  output logic [2:0]             burstCnt,
  output logic [1:0]             curWeight
);
  logic [LANE_IDX_W-1:0] curLane;
  logic [LANE_IDX_W-1:0] pick;
  logic                  curHasData;
  logic                  stay;
  logic                  found;
  logic                  slotFree;

  always_comb begin
    curHasData = 1'b0;
    curWeight  = '0;
    for (int i = 0; i < NUM_LANES; i++)
      if (curLane == LANE_IDX_W'(i)) begin
        curHasData = nonEmpty[i];
        curWeight  = laneWeight[2*i +: 2];
      end
  end

  assign stay = curHasData && (burstCnt <= {1'b0, curWeight});

  always_comb begin
    int idx;
    found = 1'b0;
    pick  = curLane;
    for (int i = 1; i <= NUM_LANES; i++) begin
      idx = (int'(curLane) + i) % NUM_LANES;
      if (!found && nonEmpty[idx]) begin
        found = 1'b1;
        pick  = LANE_IDX_W'(idx);
      end
    end
  end

  assign slotFree    = !outValid || outReady;
  assign strobe.load = slotFree && (stay || found);
  assign strobe.lane = stay ? curLane : pick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLane  <= '0;
      burstCnt <= '0;
    end else if (strobe.load) begin
      if (stay) begin
        burstCnt <= burstCnt + 1'b1;
      end else begin
        curLane  <= pick;
        burstCnt <= 3'd1;
      end
    end
  end
endmodule

// File: rtl/lane_sampler.sv
module lane_sampler
  import lane_sampler_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int LANE_W     = 8,
  parameter int TS_W       = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int CLKOFF_CYC = 8,
  parameter int SRC_ID     = 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_LANES-1:0]        laneClk,
  input  logic [NUM_LANES*LANE_W-1:0] laneData,
  input  logic [2*NUM_LANES-1:0]      laneWeight,
  input  logic                        outReady,
  output logic                        outValid,
  output logic [LANE_IDX_W-1:0]       outLane,
  output logic [TS_W-1:0]             outTs,
  output logic [LANE_W-1:0]           outData,
  output logic [FLAG_W-1:0]           outFlags,
  output logic [SRC_W-1:0]            outSrc,
  output logic [NUM_LANES-1:0]        overflow
);
  ls_strobe_t             strobe;
  logic [NUM_LANES-1:0]   nonEmpty;
  logic [TS_W-1:0]        tsNow;
  logic [2:0]             burstCnt;
  logic [1:0]             curWeight;

  assign outSrc = SRC_W'(SRC_ID);

  ls_arbiter #(.NUM_LANES(NUM_LANES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .nonEmpty   (nonEmpty),
    .laneWeight (laneWeight),
    .outValid   (outValid),
    .outReady   (outReady),
    .strobe     (strobe),
    .burstCnt   (burstCnt),
    .curWeight  (curWeight)
  );

  ls_datapath #(
    .NUM_LANES  (NUM_LANES),
    .LANE_W     (LANE_W),
    .TS_W       (TS_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .CLKOFF_CYC (CLKOFF_CYC)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .laneClk  (laneClk),
    .laneData (laneData),
    .strobe   (strobe),
    .outReady (outReady),
    .nonEmpty (nonEmpty),
    .outValid (outValid),
    .outLane  (outLane),
    .outTs    (outTs),
    .outData  (outData),
    .outFlags (outFlags),
    .overflow (overflow),
    .tsNow    (tsNow)
  );
endmodule

// File: rtl/ls_checker.sv
module ls_checker
  import lane_sampler_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 8,
  parameter int TS_W      = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  outValid,
  input logic                  outReady,
  input logic [LANE_IDX_W-1:0] outLane,
  input logic [TS_W-1:0]       outTs,
  input logic [LANE_W-1:0]     outData,
  input logic [FLAG_W-1:0]     outFlags,
  input logic [NUM_LANES-1:0]  overflow,
  input logic [TS_W-1:0]       tsNow,
  input logic                  loadStrobe,
  input logic [2:0]            burstCnt,
  input logic [1:0]            curWeight
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outLane) && $stable(outTs) &&
                              $stable(outData) && $stable(outFlags));

  assert_no_load_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !loadStrobe);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (overflow & $past(overflow)) == $past(overflow));

  assert_ts_past_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outTs < tsNow);

  assert_off_record_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outFlags[FLAG_OFF] |-> (outData == '0) && !outFlags[FLAG_RST]);

  assert_burst_R8: assert property (@(posedge clk) disable iff (!rstN)
    burstCnt <= {1'b0, curWeight} + 3'd1);
endmodule

bind lane_sampler ls_checker #(
  .NUM_LANES (NUM_LANES),
  .LANE_W    (LANE_W),
  .TS_W      (TS_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .outValid   (outValid),
  .outReady   (outReady),
  .outLane    (outLane),
  .outTs      (outTs),
  .outData    (outData),
  .outFlags   (outFlags),
  .overflow   (overflow),
  .tsNow      (tsNow),
  .loadStrobe (strobe.load),
  .burstCnt   (burstCnt),
  .curWeight  (curWeight)
);

// File: tb/sim_lane_sampler.sv
`timescale 1ns/1ps
module sim_lane_sampler;
  localparam int NL    = 4;
  localparam int DEPTH = 8;
  typedef logic [41:0] rec_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0]   laneClk = '0;
  logic [NL*8-1:0] laneData = '0;
  logic [2*NL-1:0] laneWeight = '0;
  logic          outReady = 1'b0;
  logic          outValid;
  logic [3:0]    outLane;
  logic [31:0]   outTs;
  logic [7:0]    outData;
  logic [1:0]    outFlags;
  logic [3:0]    outSrc;
  logic [NL-1:0] overflow;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit modelOn = 0;

  rec_t        expQ [NL][$];
  logic [45:0] recvQ [$];
  int          offSeen = 0;
  int          rstSeen = 0;

  lane_sampler u0 (
    .clk(clk), .rstN(rstN), .laneClk(laneClk), .laneData(laneData),
    .laneWeight(laneWeight), .outReady(outReady), .outValid(outValid),
    .outLane(outLane), .outTs(outTs), .outData(outData), .outFlags(outFlags),
    .outSrc(outSrc), .overflow(overflow)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected record stream, built from the requirements on each sampling edge
  logic       mPrev [NL];
  logic       mOff  [NL];
  logic       mHave [NL];
  int         mIdle [NL];
  logic [7:0] mLast [NL];
  logic [31:0] mTs;

  always @(posedge clk) begin
    if (!rstN) begin
      mTs = 0;
      for (int l = 0; l < NL; l++) begin
        mPrev[l] = 0; mOff[l] = 0; mHave[l] = 0; mIdle[l] = 0; mLast[l] = 0;
      end
    end else begin
      for (int l = 0; l < NL; l++) begin
        logic ed, ent, st;
        logic [7:0] d;
        d   = laneData[l*8 +: 8];
        ed  = laneClk[l] != mPrev[l];
        ent = !ed && !mOff[l] && (mIdle[l] == 7);
        st  = !ent && (ed || !mOff[l]) && (!mHave[l] || d != mLast[l]);
        if (modelOn && ent) expQ[l].push_back({2'b01, mTs, 8'h00});
        if (modelOn && st)  expQ[l].push_back({!mHave[l], 1'b0, mTs, d});
        mPrev[l] = laneClk[l];
        if (ed) mIdle[l] = 0; else if (mIdle[l] != 7) mIdle[l]++;
        if (ent) mOff[l] = 1; else if (ed) mOff[l] = 0;
        if (ent) mHave[l] = 0; else if (st) mHave[l] = 1;
        if (st) mLast[l] = d;
      end
      mTs++;
    end
  end

  task automatic observe();
    rec_t got, exp;
    if (rstN && outValid && outReady) begin
      got = {outFlags, outTs, outData};
      check(outSrc == 4'd1, "R1 source number", outSrc, 1);
      if (modelOn) begin
        if (expQ[outLane].size() == 0) begin
          check(0, "R3 unexpected record", got, 0);
        end else begin
          exp = expQ[outLane].pop_front();
          if (exp[41:40] == 2'b01) offSeen++;
          if (exp[41:40] == 2'b10) rstSeen++;
          check(got[41:40] == exp[41:40] && got[7:0] == exp[7:0],
                exp[40] ? "R4 clock-off record" : (exp[41] ? "R5 restart record" : "R3/R6 data record"),
                got, exp);
          check(got[39:8] == exp[39:8], "R2 timestamp", got[39:8], exp[39:8]);
        end
      end else begin
        recvQ.push_back({outLane, got});
      end
    end
  endtask

  task automatic tick();
    observe();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic toggleAll();
    laneClk = ~laneClk;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    outReady = 1'b0;
    repeat (3) begin toggleAll(); tick(); end
    check(outValid == 1'b0, "R1 valid in reset", outValid, 0);
    check(overflow == '0, "R1 overflow in reset", overflow, 0);
    rstN = 1'b1;
  endtask

  // Expected lane order when every lane starts with cnt records and output drains freely
  int expSeq [64];
  task automatic buildArb(input int cnt);
    int left [NL];
    int cur, b, g;
    cur = 0; b = 0;
    for (int l = 0; l < NL; l++) left[l] = cnt;
    for (int n = 0; n < NL*cnt; n++) begin
      if (left[cur] > 0 && b <= int'(laneWeight[2*cur +: 2])) begin
        g = cur; b++;
      end else begin
        g = cur;
        for (int i = NL; i >= 1; i--)
          if (left[(cur+i)%NL] > 0) g = (cur+i)%NL;
        cur = g; b = 1;
      end
      left[g]--;
      expSeq[n] = g;
    end
  endtask

  initial begin
    int stopLeft [NL];
    int seed;
    int n0;
    logic [3:0] hl;
    logic [7:0] hd;
    seed = $urandom(32'h1eaf);
    @(negedge clk);

    // Phase A: random traffic against the expected stream
    laneWeight = 8'($urandom);
    modelOn = 1;
    doReset();
    for (int l = 0; l < NL; l++) stopLeft[l] = 0;
    for (int c = 0; c < 3000; c++) begin
      for (int l = 0; l < NL; l++) begin
        if (stopLeft[l] > 0) stopLeft[l]--;
        else begin
          laneClk[l] = ~laneClk[l];
          if ($urandom % 150 == 0) stopLeft[l] = 6 + int'($urandom % 9);
        end
        if ($urandom % 16 == 0) laneData[l*8 +: 8] = 8'($urandom);
      end
      outReady = ($urandom % 8) != 0;
      tick();
    end
    outReady = 1'b1;
    repeat (120) begin toggleAll(); tick(); end
    for (int l = 0; l < NL; l++)
      check(expQ[l].size() == 0, "R3 missing records", expQ[l].size(), 0);
    check(overflow == '0, "R7 no drop at low load", overflow, 0);
    check(offSeen > 0, "R4 clock-off seen", offSeen, 1);
    check(rstSeen > NL, "R5 resume seen", rstSeen, NL + 1);

    // Phase B: overflow with the output stalled
    modelOn = 0;
    recvQ.delete();
    laneData = '0;
    doReset();
    for (int k = 0; k < DEPTH + 4; k++) begin
      laneData[7:0] = 8'(8'h10 + k);
      toggleAll();
      tick();
    end
    check(overflow == 4'b0001, "R7 overflow set", overflow, 4'b0001);
    repeat (5) begin toggleAll(); tick(); end
    check(overflow == 4'b0001, "R7 overflow sticky", overflow, 4'b0001);
    outReady = 1'b1;
    repeat (40) begin toggleAll(); tick(); end
    check(overflow == 4'b0001, "R7 sticky after drain", overflow, 4'b0001);
    n0 = 0;
    foreach (recvQ[i]) if (recvQ[i][45:42] == 0) begin
      check(recvQ[i][7:0] == 8'(8'h10 + n0), "R7 kept oldest", recvQ[i][7:0], 8'h10 + n0);
      n0++;
    end
    check(n0 == DEPTH + 1, "R7 kept count", n0, DEPTH + 1);

    // Phase C: weighted arbitration from a full backlog
    recvQ.delete();
    laneWeight = {2'd0, 2'd2, 2'd0, 2'd1};
    for (int l = 0; l < NL; l++) laneData[l*8 +: 8] = 8'(l * 32);
    doReset();
    for (int k = 1; k <= 4; k++) begin
      toggleAll();
      tick();
      if (k < 4) for (int l = 0; l < NL; l++) laneData[l*8 +: 8] = 8'(l * 32 + k);
    end
    repeat (20) begin toggleAll(); tick(); end
    check(outValid == 1'b1, "R9 valid while stalled", outValid, 1);
    check(outLane == 4'd0, "R8 lane 0 first", outLane, 0);
    check(outTs == 32'd0, "R2 first stamp", outTs, 0);
    hl = outLane; hd = outData;
    toggleAll(); tick();
    check(outValid && outLane == hl && outData == hd, "R9 held record", {outLane, outData}, {hl, hd});
    outReady = 1'b1;
    repeat (40) begin toggleAll(); tick(); end
    buildArb(4);
    check(recvQ.size() == 16, "R8 record count", recvQ.size(), 16);
    for (int i = 0; i < 16 && i < recvQ.size(); i++)
      check(recvQ[i][45:42] == 4'(expSeq[i]), "R8 grant order", recvQ[i][45:42], expSeq[i]);
    for (int l = 0; l < NL; l++) begin
      n0 = 0;
      foreach (recvQ[i]) if (recvQ[i][45:42] == 4'(l)) begin
        check(recvQ[i][7:0] == 8'(l * 32 + n0), "R6 lane order", recvQ[i][7:0], l * 32 + n0);
        n0++;
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule